// File: doc/BRIEF.md
# Settable Time-of-Day Counter

This block keeps the time of day on a 24-hour dial. A divider turns the system clock into a one-cycle tick once per second. Seconds, minutes and hours are each presented as two BCD digits, ready for a display driver. All fields sit in the one clock domain and advance through enables, so no field is clocked by a derived clock.

A one-cycle pulse on the set control flips the block between running and setting. While setting, the seconds field freezes. The minute and hour fields copy a button-driven preset every cycle, and presets that are out of range are replaced by zero. A second pulse resumes counting from the loaded values. A single-cycle strobe marks each top of the hour.

Top module: `tod_clock`

## Requirements
- R1: After reset the outputs read 00:00:00, set_mode is 0 and hour_strobe is 0.
- R2: In run mode the seconds field advances once every CLK_HZ clock cycles, on the edge where the divider count reaches CLK_HZ-1; it is BCD (upper nibble tens 0..5, lower nibble units 0..9) and wraps from 59 to 00.
- R3: The minute field, same BCD layout, advances only when seconds wrap from 59 to 00, and wraps from 59 to 00 itself.
- R4: The hour field advances only when seconds and minutes wrap together (59:59 to 00:00), wraps from 23 to 00, and is shown as two BCD digits (hour 19 reads 8'h19).
- R5: hour_strobe is high for exactly one cycle, the first cycle in which the outputs show minutes 00 and seconds 00 after a 59:59 rollover; the seconds running from 00 to 59 with minutes at 00 raise no further strobe.
- R6: A cycle with set_toggle high flips the mode at that clock edge; set_mode reads 1 in set mode and 0 in run mode.
- R7: In set mode the seconds field holds its value. Minutes and hours take preset_min (BCD) and preset_hr (binary) at every clock edge, and show them from the next cycle.
- R8: A minute preset with tens above 5 or units above 9 loads as 00; an hour preset above 23 loads as 00.
- R9: Leaving set mode resumes counting from the loaded hours and minutes and the held seconds, with no reset of any field.
- R10: hour_strobe is never raised for a second that elapses in set mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_toggle | input | 1 | One-cycle pulse that flips run/set mode |
| preset_min | input | 8 | Minute preset, two BCD digits |
| preset_hr | input | 5 | Hour preset, binary |
| set_mode | output | 1 | 1 while in set mode |
| hr_bcd | output | 8 | Hours, two BCD digits |
| min_bcd | output | 8 | Minutes, two BCD digits |
| sec_bcd | output | 8 | Seconds, two BCD digits |
| hour_strobe | output | 1 | One-cycle top-of-hour pulse |

## Verification
The bench runs a small divider setting and moves the clock to minute 59 of every hour in turn, so that each hour rollover is seen, and the 23-to-00 midnight wrap as well. A design that drives the hour from a stale minute carry would step the hour twice or strobe again while minutes sit at 00, and the per-hour strobe count catches that. Every valid minute preset and a set of invalid nibble patterns are loaded: a missing clamp shows digits above 5 or 9. Set mode is held across many ticks, so a seconds field that kept counting, or a strobe raised while setting, shows up at the outputs.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int HR_W = 5;
  localparam logic [7:0] BCD_LAST = 8'h59;

  // Next value of a two-digit BCD field that wraps 59 -> 00.
  function automatic logic [7:0] bcd60_next(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) begin
      if (v[7:4] == 4'd5) r = 8'h00;
      else                r = {v[7:4] + 4'd1, 4'd0};
    end else begin
      r = {v[7:4], v[3:0] + 4'd1};
    end
    return r;
  endfunction

  // Replace an illegal BCD minute/second pattern by zero.
  function automatic logic [7:0] bcd60_clamp(input logic [7:0] v);
    return (v[7:4] <= 4'd5 && v[3:0] <= 4'd9) ? v : 8'h00;
  endfunction

  // Binary hour (0..29) to two BCD digits.
  function automatic logic [7:0] hour_to_bcd(input logic [HR_W-1:0] h);
    logic [3:0] tens;
    logic [4:0] units;
    if (h >= HR_W'(20))      tens = 4'd2;
    else if (h >= HR_W'(10)) tens = 4'd1;
    else                     tens = 4'd0;
    units = h - 5'(tens * 10);
    return {tens, units[3:0]};
  endfunction
endpackage

// File: rtl/tod_tick.sv
module tod_tick #(
  parameter int CLK_HZ = 12_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (CLK_HZ > 2) ? $clog2(CLK_HZ) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_HZ - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/tod_bcd60.sv
module tod_bcd60
  import tod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc_i,
  input  logic       load_i,
  input  logic [7:0] load_val_i,
  output logic [7:0] val_o,
  output logic       last_o
);
  logic [7:0] val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= 8'h00;
    else if (load_i) val_q <= bcd60_clamp(load_val_i);
    else if (inc_i)  val_q <= bcd60_next(val_q);
  end

  assign val_o  = val_q;
  assign last_o = (val_q == BCD_LAST);
endmodule

// File: rtl/tod_hours.sv
module tod_hours
  import tod_pkg::*;
#(
  parameter int HOURS = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc_i,
  input  logic            load_i,
  input  logic [HR_W-1:0] load_val_i,
  output logic [HR_W-1:0] val_o
);
  localparam logic [HR_W-1:0] TOP = HR_W'(HOURS - 1);

  logic [HR_W-1:0] val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (load_i) begin
      val_q <= (load_val_i <= TOP) ? load_val_i : '0;
    end else if (inc_i) begin
      val_q <= (val_q == TOP) ? '0 : val_q + HR_W'(1);
    end
  end

  assign val_o = val_q;
endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int CLK_HZ = 12_000_000,
  parameter int HOURS  = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_toggle,
  input  logic [7:0] preset_min,
  input  logic [4:0] preset_hr,
  output logic       set_mode,
  output logic [7:0] hr_bcd,
  output logic [7:0] min_bcd,
  output logic [7:0] sec_bcd,
  output logic       hour_strobe
);
  localparam int NFLD = 2;  // field 0: seconds, field 1: minutes

  logic            mode_q;
  logic            strobe_q;
  logic            tick;
  logic            sec_tick;
  logic            sec_wrap;
  logic            min_wrap;
  logic [HR_W-1:0] hr_val;

  logic [7:0] fld_val    [NFLD];
  logic       fld_last   [NFLD];
  logic       fld_inc    [NFLD];
  logic       fld_load   [NFLD];
  logic [7:0] fld_preset [NFLD];

  tod_tick #(.CLK_HZ(CLK_HZ)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  // Event chain: the hour carry is the product of both lower wraps in
  // the same cycle, so a minute field parked at 00 cannot re-fire it.
  assign sec_tick = tick & ~mode_q;
  assign sec_wrap = sec_tick & fld_last[0];
  assign min_wrap = sec_wrap & fld_last[1];

  assign fld_inc[0]    = sec_tick;
  assign fld_load[0]   = 1'b0;
  assign fld_preset[0] = 8'h00;
  assign fld_inc[1]    = sec_wrap;
  assign fld_load[1]   = mode_q;
  assign fld_preset[1] = preset_min;

  for (genvar g = 0; g < NFLD; g++) begin : g_fld
    tod_bcd60 u_fld (
      .clk        (clk),
      .rst_n      (rst_n),
      .inc_i      (fld_inc[g]),
      .load_i     (fld_load[g]),
      .load_val_i (fld_preset[g]),
      .val_o      (fld_val[g]),
      .last_o     (fld_last[g])
    );
  end

  tod_hours #(.HOURS(HOURS)) u_hours (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc_i      (min_wrap),
    .load_i     (mode_q),
    .load_val_i (preset_hr),
    .val_o      (hr_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      mode_q   <= mode_q ^ set_toggle;
      strobe_q <= min_wrap;
    end
  end

  assign set_mode    = mode_q;
  assign sec_bcd     = fld_val[0];
  assign min_bcd     = fld_val[1];
  assign hr_bcd      = hour_to_bcd(hr_val);
  assign hour_strobe = strobe_q;
endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       set_mode,
  input logic       tick,
  input logic [7:0] sec_bcd,
  input logic [7:0] min_bcd,
  input logic [7:0] hr_bcd,
  input logic       hour_strobe
);
  p_sec_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_bcd[7:4] <= 4'd5 && sec_bcd[3:0] <= 4'd9);

  p_sec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_mode && tick && sec_bcd != 8'h59) |=> sec_bcd != $past(sec_bcd));

  p_min_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    min_bcd[7:4] <= 4'd5 && min_bcd[3:0] <= 4'd9);

  p_hr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hr_bcd <= 8'h23 && hr_bcd[3:0] <= 4'd9);

  p_strobe_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hour_strobe |-> (min_bcd == 8'h00 && sec_bcd == 8'h00));

  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hour_strobe |=> !hour_strobe);

  p_set_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mode && $past(set_mode)) |-> $stable(sec_bcd));

  p_no_strobe_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hour_strobe |-> !$past(set_mode));
endmodule

bind tod_clock tod_clock_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .set_mode    (set_mode),
  .tick        (tick),
  .sec_bcd     (sec_bcd),
  .min_bcd     (min_bcd),
  .hr_bcd      (hr_bcd),
  .hour_strobe (hour_strobe)
);

// File: tb/tb_tod_clock.sv
module tb_tod_clock;
  localparam int HZ = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       set_toggle = 1'b0;
  logic [7:0] preset_min = 8'h00;
  logic [4:0] preset_hr = 5'd0;
  logic       set_mode;
  logic [7:0] hr_bcd, min_bcd, sec_bcd;
  logic       hour_strobe;

  int checks = 0;
  int errors = 0;
  int strobe_cnt = 0;
  int set_strobes = 0;
  bit cmp_on = 0;

  // reference state: seconds of day, divider phase, mode, strobe
  int m_t, m_phase;
  bit m_mode, m_strobe;

  always #10 clk = ~clk;

  tod_clock #(.CLK_HZ(HZ)) dut (
    .clk(clk), .rst_n(rst_n), .set_toggle(set_toggle),
    .preset_min(preset_min), .preset_hr(preset_hr),
    .set_mode(set_mode), .hr_bcd(hr_bcd), .min_bcd(min_bcd),
    .sec_bcd(sec_bcd), .hour_strobe(hour_strobe)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Arithmetic reference of the time of day, advanced at each edge.
  always @(posedge clk) begin
    bit tk;
    int hh, mm;
    if (!rst_n) begin
      m_t = 0; m_phase = 0; m_mode = 0; m_strobe = 0;
    end else begin
      tk = (m_phase == HZ - 1);
      m_phase = tk ? 0 : m_phase + 1;
      m_strobe = 0;
      if (m_mode) begin
        hh = (preset_hr < 24) ? int'(preset_hr) : 0;
        mm = (preset_min[7:4] < 6 && preset_min[3:0] < 10) ?
             int'(preset_min[7:4]) * 10 + int'(preset_min[3:0]) : 0;
        m_t = hh * 3600 + mm * 60 + (m_t % 60);
      end else if (tk) begin
        m_t = (m_t + 1) % 86400;
        m_strobe = (m_t % 3600 == 0);
      end
      if (set_toggle) m_mode = !m_mode;
    end
  end

  // Continuous comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk(sec_bcd == to_bcd(m_t % 60), "R2", "seconds", sec_bcd, to_bcd(m_t % 60));
      chk(min_bcd == to_bcd((m_t / 60) % 60), "R3", "minutes", min_bcd, to_bcd((m_t / 60) % 60));
      chk(hr_bcd == to_bcd(m_t / 3600), "R4", "hours", hr_bcd, to_bcd(m_t / 3600));
      chk(set_mode == m_mode, "R6", "set_mode", set_mode, m_mode);
      chk(hour_strobe == m_strobe, "R5", "hour_strobe", hour_strobe, m_strobe);
    end
    if (rst_n && hour_strobe) begin
      strobe_cnt++;
      if (set_mode) set_strobes++;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic flip_mode();
    @(negedge clk); set_toggle = 1'b1;
    @(negedge clk); set_toggle = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int sc0, sec_hold, set_s0;
    logic [7:0] bad_min [4];
    bad_min[0] = 8'h60; bad_min[1] = 8'h9A; bad_min[2] = 8'h3F; bad_min[3] = 8'hFF;

    cycles(3);
    rst_n = 1'b1;
    // R1: still the reset state before the first counting edge
    chk(sec_bcd == 8'h00 && min_bcd == 8'h00 && hr_bcd == 8'h00, "R1", "time",
        {hr_bcd, min_bcd, sec_bcd}, 0);
    chk(set_mode == 1'b0, "R1", "set_mode", set_mode, 0);
    chk(hour_strobe == 1'b0, "R1", "hour_strobe", hour_strobe, 0);
    cmp_on = 1;

    // R2 R3 R5: one full hour from midnight, one strobe
    cycles(3601 * HZ + 2);
    chk(strobe_cnt == 1, "R5", "strobes in first hour", strobe_cnt, 1);
    chk(hr_bcd == 8'h01, "R4", "hour after 3601 s", hr_bcd, 8'h01);

    // R4 R5 R7 R9: every hour, parked at minute 59 then released
    for (int h = 0; h < 24; h++) begin
      preset_hr = 5'(h);
      preset_min = 8'h59;
      flip_mode();
      chk(set_mode == 1'b1, "R6", "enter set", set_mode, 1);
      cycles(3);
      chk(min_bcd == 8'h59 && hr_bcd == to_bcd(h), "R7", "loaded preset",
          {hr_bcd, min_bcd}, {to_bcd(h), 8'h59});
      flip_mode();
      chk(hr_bcd == to_bcd(h) && min_bcd == 8'h59, "R9", "resume from preset",
          {hr_bcd, min_bcd}, {to_bcd(h), 8'h59});
      sc0 = strobe_cnt;
      cycles(70 * HZ);
      chk(strobe_cnt - sc0 == 1, "R5", "one strobe per hour", strobe_cnt - sc0, 1);
      chk(hr_bcd == to_bcd((h + 1) % 24), "R4", "hour carry", hr_bcd, to_bcd((h + 1) % 24));
    end

    // R7 R8 R10: set mode held across many ticks
    flip_mode();
    set_s0 = set_strobes;
    sec_hold = sec_bcd;
    preset_hr = 5'd3;
    for (int i = 0; i < 4; i++) begin
      preset_min = bad_min[i];
      cycles(2);
      chk(min_bcd == 8'h00, "R8", "bad minute preset", min_bcd, 0);
    end
    preset_min = 8'h12;
    preset_hr = 5'd24;
    cycles(2);
    chk(hr_bcd == 8'h00, "R8", "hour preset 24", hr_bcd, 0);
    preset_hr = 5'd31;
    cycles(2);
    chk(hr_bcd == 8'h00, "R8", "hour preset 31", hr_bcd, 0);
    preset_hr = 5'd23;
    for (int m = 0; m < 60; m++) begin
      preset_min = to_bcd(m);
      cycles(2);
      chk(min_bcd == to_bcd(m), "R7", "minute preset sweep", min_bcd, to_bcd(m));
    end
    preset_min = 8'h59;
    cycles(20 * HZ);
    chk(sec_bcd == 8'(sec_hold), "R7", "seconds held", sec_bcd, sec_hold);
    chk(set_strobes == set_s0 && hour_strobe == 1'b0, "R10", "strobe in set mode",
        set_strobes - set_s0, 0);
    flip_mode();
    chk(set_mode == 1'b0, "R6", "leave set", set_mode, 0);
    sc0 = strobe_cnt;
    cycles(62 * HZ);
    chk(strobe_cnt - sc0 == 1 && hr_bcd == 8'h00, "R9", "midnight after resume",
        {strobe_cnt - sc0, hr_bcd}, 1);

    cmp_on = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule